// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Access Port

This block is a serial test port for a memory device. It uses a small instruction set and a deliberately reduced boundary-scan function. A tester drives a test clock, a mode-select line and a serial data input. The block walks the standard sixteen-state test-port controller and returns serial data on an output that is enabled only while a register is being shifted. Five instructions are decoded from a 3-bit instruction register. Each instruction picks one of three data registers: a 32-bit identification register, a 1-bit bypass register, or a boundary-scan register. The boundary-scan register takes a parallel snapshot of the device's pins.

The boundary-scan cells only capture and shift. They never drive pins, and the Update-DR state changes nothing. The all-zeros instruction therefore only samples the pins, and it also raises an output-disable signal that tells the device to float its outputs. The sample-with-high-impedance instruction raises the same signal. Because of this reduced behaviour the port does not comply with the full boundary-scan standard.

The test clock is expected to run far slower than the device clock. A pin that toggles during Capture-DR is captured with an undefined value, so users must hold pins stable when they need a repeatable snapshot.

Top module: `scan_tap`

## Requirements
- R1: The controller follows the sixteen-state test-port graph, with mode-select sampled on the rising test-clock edge. Five consecutive rising edges with mode-select high reach Test-Logic-Reset from any state.
- R2: After reset, and from the edge that enters Test-Logic-Reset, the active instruction is the identification instruction (code 001). A following Shift-DR therefore returns the identification register, and output-disable is low.
- R3: In Shift-IR the instruction register shifts least-significant bit first: TDI enters bit 2 and bit 0 appears on TDO. Capture-IR loads 001, so the bits read out are 1, 0, 0. A shifted code becomes active only on the edge that leaves Update-IR, and output-disable does not change before that edge.
- R4: Code 001 selects a 32-bit identification register. Capture-DR loads it with the parameter value, with bit 0 forced to 1, and it shifts out least-significant bit first.
- R5: Code 111 selects a 1-bit bypass register that captures 0. The unused codes 011, 101 and 110 behave exactly like 111 and leave output-disable low.
- R6: Code 100 (sample) loads all of pin_vec into the boundary-scan register at Capture-DR. Shift-DR then shifts it out bit 0 first, with TDI entering the top cell. Output-disable stays low.
- R7: Code 000 behaves as R6 and also holds output-disable high while it is active.
- R8: Code 010 selects the boundary-scan register as R6 and holds output-disable high while it is active.
- R9: Passing through Update-DR leaves the active instruction and output-disable unchanged.
- R10: TDO and tdo_en change only on the falling test-clock edge. tdo_en is high only in Shift-IR and Shift-DR, and TDO is 0 whenever tdo_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset, synchronous to tck |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pin_vec | input | BSR_LEN | Device pins sampled at Capture-DR |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_en | output | 1 | High while tdo carries shifted data |
| out_disable | output | 1 | Asks the device to float its outputs |

## Verification
The bench walks every 3-bit code, including the three unused ones. For each code it checks the chain length and the captured contents at TDO. A decoder that gave an unused code its own behaviour would show the wrong length or a nonzero first bit.

The bench also reads output-disable while the controller sits in Update-IR and in Update-DR. A design that committed the instruction early, or that let Update-DR act, would change that signal one state too soon.

Two further checks cover reset and clock edges. Test-Logic-Reset is reached from inside Shift-IR and Shift-DR using exactly five high mode-select cycles, and the next Shift-DR must return the identification value. A design that restored the default instruction one edge late would leave output-disable high at that point. The bench also samples TDO just after a rising edge to catch a serial output retimed on the wrong edge.

// File: rtl/scan_tap_pkg.sv
// Shared types and codes for the reduced boundary-scan test port.
// Assumes a 3-bit instruction register; the code values set the decode.
package scan_tap_pkg;

    localparam int IR_LEN = 3;
    localparam int ID_LEN = 32;

    localparam logic [IR_LEN-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_LEN-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_LEN-1:0] OP_SAMPZ   = 3'b010;
    localparam logic [IR_LEN-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [IR_LEN-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_LEN-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        TS_RESET   = 4'd0,
        TS_IDLE    = 4'd1,
        TS_SEL_DR  = 4'd2,
        TS_CAP_DR  = 4'd3,
        TS_SH_DR   = 4'd4,
        TS_EX1_DR  = 4'd5,
        TS_PAU_DR  = 4'd6,
        TS_EX2_DR  = 4'd7,
        TS_UPD_DR  = 4'd8,
        TS_SEL_IR  = 4'd9,
        TS_CAP_IR  = 4'd10,
        TS_SH_IR   = 4'd11,
        TS_EX1_IR  = 4'd12,
        TS_PAU_IR  = 4'd13,
        TS_EX2_IR  = 4'd14,
        TS_UPD_IR  = 4'd15
    } tap_state_t;

    typedef enum logic [1:0] {
        SEL_BYP = 2'd0,
        SEL_ID  = 2'd1,
        SEL_BSR = 2'd2
    } dr_sel_t;

endpackage

// File: rtl/scan_tap_fsm.sv
// Sixteen-state test-port controller.
// Assumes tms is sampled on the rising edge of tck; reset puts the controller in TS_RESET.
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state,
    output tap_state_t state_nxt
);

    // Next-state graph driven by tms.
    always_comb begin
        unique case (state)
            TS_RESET:  state_nxt = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   state_nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: state_nxt = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: state_nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  state_nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: state_nxt = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: state_nxt = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: state_nxt = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: state_nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: state_nxt = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: state_nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  state_nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: state_nxt = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: state_nxt = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: state_nxt = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: state_nxt = tms ? TS_SEL_DR : TS_IDLE;
            default:   state_nxt = TS_RESET;
        endcase
    end

    // State register.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= TS_RESET;
        else        state <= state_nxt;
    end

endmodule

// File: rtl/scan_tap_ir.sv
// Instruction register: a capture/shift stage, the active instruction, and decode.
// Assumes unused codes fall back to bypass; the default instruction is loaded on any edge that enters reset.
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic              tck,
    input  logic              rst_n,
    input  tap_state_t        state,
    input  tap_state_t        state_nxt,
    input  logic              tdi,
    output logic [IR_LEN-1:0] ir_shift,
    output logic [IR_LEN-1:0] ir_active,
    output dr_sel_t           dr_sel,
    output logic              hiz
);

    // Shift stage: capture the fixed pattern, then shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                 ir_shift <= IR_CAPTURE;
        else if (state == TS_CAP_IR) ir_shift <= IR_CAPTURE;
        else if (state == TS_SH_IR)  ir_shift <= {tdi, ir_shift[IR_LEN-1:1]};
    end

    // Active instruction: the default on reset entry, the shifted code when leaving update.
    always_ff @(posedge tck) begin
        if (!rst_n)                    ir_active <= OP_IDCODE;
        else if (state_nxt == TS_RESET) ir_active <= OP_IDCODE;
        else if (state == TS_UPD_IR)    ir_active <= ir_shift;
    end

    // Decode into a data-register select and the output-float request.
    always_comb begin
        dr_sel = SEL_BYP;
        hiz    = 1'b0;
        case (ir_active)
            OP_EXTEST: begin dr_sel = SEL_BSR; hiz = 1'b1; end
            OP_IDCODE: dr_sel = SEL_ID;
            OP_SAMPZ:  begin dr_sel = SEL_BSR; hiz = 1'b1; end
            OP_SAMPLE: dr_sel = SEL_BSR;
            default:   dr_sel = SEL_BYP;
        endcase
    end

endmodule

// File: rtl/scan_tap_bcell.sv
// One boundary-scan cell with capture and shift only; it never drives a pin.
// Assumes capture and shift are never asserted together.
module scan_tap_bcell (
    input  logic tck,
    input  logic rst_n,
    input  logic cap_en,
    input  logic sh_en,
    input  logic pin,
    input  logic sin,
    output logic q
);

    // Cell flop: take the pin at capture, the upstream bit at shift.
    always_ff @(posedge tck) begin
        if (!rst_n)     q <= 1'b0;
        else if (cap_en) q <= pin;
        else if (sh_en)  q <= sin;
    end

endmodule

// File: rtl/scan_tap_dr.sv
// Data registers: bypass, identification and boundary-scan, plus the serial-out mux.
// Assumes only the selected register shifts; Update-DR has no effect on any of them.
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int                BSR_LEN  = 16,
    parameter logic [ID_LEN-1:0] ID_VALUE = 32'h4C6E_0F12
) (
    input  logic               tck,
    input  logic               rst_n,
    input  tap_state_t         state,
    input  dr_sel_t            dr_sel,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_vec,
    output logic               dr_tdo,
    output logic               byp_q
);

    localparam logic [ID_LEN-1:0] ID_CAP = ID_VALUE | {{(ID_LEN-1){1'b0}}, 1'b1};

    logic               cap_dr;
    logic               sh_dr;
    logic [ID_LEN-1:0]  id_q;
    logic [BSR_LEN-1:0] bsr_q;
    logic [BSR_LEN-1:0] bsr_in;

    assign cap_dr = (state == TS_CAP_DR);
    assign sh_dr  = (state == TS_SH_DR);

    // Bypass bit: captures zero, shifts when selected.
    always_ff @(posedge tck) begin
        if (!rst_n)                         byp_q <= 1'b0;
        else if (cap_dr)                    byp_q <= 1'b0;
        else if (sh_dr && dr_sel == SEL_BYP) byp_q <= tdi;
    end

    // Identification register: captures the constant with bit 0 set, shifts when selected.
    always_ff @(posedge tck) begin
        if (!rst_n)                        id_q <= ID_CAP;
        else if (cap_dr && dr_sel == SEL_ID) id_q <= ID_CAP;
        else if (sh_dr && dr_sel == SEL_ID)  id_q <= {tdi, id_q[ID_LEN-1:1]};
    end

    // Boundary chain: tdi feeds the top cell and bit 0 is the serial output.
    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
        if (i == BSR_LEN - 1) begin : g_top
            assign bsr_in[i] = tdi;
        end else begin : g_mid
            assign bsr_in[i] = bsr_q[i+1];
        end
        scan_tap_bcell u_cell (
            .tck    (tck),
            .rst_n  (rst_n),
            .cap_en (cap_dr && dr_sel == SEL_BSR),
            .sh_en  (sh_dr && dr_sel == SEL_BSR),
            .pin    (pin_vec[i]),
            .sin    (bsr_in[i]),
            .q      (bsr_q[i])
        );
    end

    // Serial output of the selected register.
    always_comb begin
        unique case (dr_sel)
            SEL_ID:  dr_tdo = id_q[0];
            SEL_BSR: dr_tdo = bsr_q[0];
            default: dr_tdo = byp_q;
        endcase
    end

endmodule

// File: rtl/scan_tap.sv
// Top of the reduced boundary-scan test port: controller, instruction and data registers, falling-edge output.
// Assumes rst_n is synchronous to tck; out_disable follows the active instruction.
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int                BSR_LEN  = 16,
    parameter logic [ID_LEN-1:0] ID_VALUE = 32'h4C6E_0F12
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_vec,
    output logic               tdo,
    output logic               tdo_en,
    output logic               out_disable
);

    tap_state_t        tap_state;
    tap_state_t        tap_next;
    logic [IR_LEN-1:0] ir_shift;
    logic [IR_LEN-1:0] ir_active;
    dr_sel_t           dr_sel;
    logic              dr_tdo;
    logic              byp_q;

    scan_tap_fsm u_fsm (
        .tck       (tck),
        .rst_n     (rst_n),
        .tms       (tms),
        .state     (tap_state),
        .state_nxt (tap_next)
    );

    scan_tap_ir u_ir (
        .tck       (tck),
        .rst_n     (rst_n),
        .state     (tap_state),
        .state_nxt (tap_next),
        .tdi       (tdi),
        .ir_shift  (ir_shift),
        .ir_active (ir_active),
        .dr_sel    (dr_sel),
        .hiz       (out_disable)
    );

    scan_tap_dr #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck     (tck),
        .rst_n   (rst_n),
        .state   (tap_state),
        .dr_sel  (dr_sel),
        .tdi     (tdi),
        .pin_vec (pin_vec),
        .dr_tdo  (dr_tdo),
        .byp_q   (byp_q)
    );

    // Falling-edge retiming of the serial output and its enable.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (tap_state == TS_SH_IR) || (tap_state == TS_SH_DR);
            if (tap_state == TS_SH_IR)      tdo <= ir_shift[0];
            else if (tap_state == TS_SH_DR) tdo <= dr_tdo;
            else                            tdo <= 1'b0;
        end
    end

endmodule

// File: rtl/scan_tap_chk.sv
// Property checker for scan_tap, attached through bind.
// Assumes it sees the controller state and the instruction registers of the top.
module scan_tap_chk
    import scan_tap_pkg::*;
(
    input logic              tck,
    input logic              rst_n,
    input logic              tms,
    input logic              tdo_en,
    input logic              out_disable,
    input tap_state_t        tap_state,
    input logic [IR_LEN-1:0] ir_shift,
    input logic [IR_LEN-1:0] ir_active,
    input logic              byp_q
);

    logic [2:0] ones_cnt;

    // Count consecutive high tms edges, saturating at five.
    always_ff @(posedge tck) begin
        if (!rst_n)              ones_cnt <= 3'd0;
        else if (!tms)           ones_cnt <= 3'd0;
        else if (ones_cnt < 3'd5) ones_cnt <= ones_cnt + 3'd1;
    end

    assert_five_high_reset_R1: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_cnt == 3'd5) |-> (tap_state == TS_RESET));

    assert_reset_default_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == TS_RESET) |-> (ir_active == OP_IDCODE));

    assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == TS_CAP_IR) |=> (ir_shift == IR_CAPTURE));

    assert_ir_hold_R3: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state != TS_UPD_IR && tap_state != TS_SEL_IR && tap_state != TS_RESET)
        |=> $stable(ir_active));

    assert_bypass_zero_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == TS_CAP_DR) |=> (byp_q == 1'b0));

    assert_float_on_update_R8: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(out_disable) |-> ($past(tap_state) == TS_UPD_IR));

    assert_update_dr_inert_R9: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == TS_UPD_DR) |=> ($stable(out_disable) && $stable(ir_active)));

    assert_en_in_shift_R10: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en |-> (tap_state == TS_SH_IR || tap_state == TS_SH_DR));

endmodule

bind scan_tap scan_tap_chk u_chk (
    .tck         (tck),
    .rst_n       (rst_n),
    .tms         (tms),
    .tdo_en      (tdo_en),
    .out_disable (out_disable),
    .tap_state   (tap_state),
    .ir_shift    (ir_shift),
    .ir_active   (ir_active),
    .byp_q       (byp_q)
);

// File: tb/sim_scan_tap.sv
module sim_scan_tap;

    localparam int          BSR_LEN = 16;
    localparam logic [31:0] ID_VAL  = 32'h4C6E_0F12;
    localparam logic [31:0] ID_EXP  = 32'h4C6E_0F13;
    localparam int          NSH     = 48;
    localparam logic [63:0] DIN     = 64'h0000_9D3A_61F5_C7B8;

    // Vector: {code[2:0], kind[1:0] (0 bypass, 1 id, 2 boundary), expected out_disable}
    localparam logic [5:0] VEC [8] = '{
        {3'b000, 2'd2, 1'b1},
        {3'b001, 2'd1, 1'b0},
        {3'b010, 2'd2, 1'b1},
        {3'b011, 2'd0, 1'b0},
        {3'b100, 2'd2, 1'b0},
        {3'b101, 2'd0, 1'b0},
        {3'b110, 2'd0, 1'b0},
        {3'b111, 2'd0, 1'b0}
    };

    logic               tck = 1'b0;
    logic               rst_n = 1'b0;
    logic               tms = 1'b1;
    logic               tdi = 1'b0;
    logic [BSR_LEN-1:0] pin_vec = '0;
    logic               tdo;
    logic               tdo_en;
    logic               out_disable;
    int                 checks = 0;
    int                 errors = 0;

    always #5 tck = ~tck;

    scan_tap #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VAL)) u0 (
        .tck (tck), .rst_n (rst_n), .tms (tms), .tdi (tdi), .pin_vec (pin_vec),
        .tdo (tdo), .tdo_en (tdo_en), .out_disable (out_disable)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    // From Run-Test-Idle: load a code, return the captured bits; ends in Run-Test-Idle.
    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
        logic od0;
        od0 = out_disable;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            cap[i] = tdo;
            step(i == 2, code[i]);
        end
        step(1, 0);
        check("R3 no change before update", {63'd0, out_disable}, {63'd0, od0});
        step(0, 0);
    endtask

    // From Run-Test-Idle: shift n bits through the DR path; ends in Run-Test-Idle.
    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic en_ok;
        logic od0;
        od0 = out_disable;
        dout = '0;
        en_ok = 1'b1;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            if (tdo_en !== 1'b1) en_ok = 1'b0;
            step(i == n - 1, din[i]);
        end
        check("R10 enable during shift", {63'd0, en_ok}, 64'd1);
        check("R10 enable off at exit", {62'd0, tdo_en, tdo}, 64'd0);
        step(1, 0);
        check("R9 update-dr inert", {63'd0, out_disable}, {63'd0, od0});
        step(0, 0);
    endtask

    function automatic logic [63:0] expect_chain(input int len, input logic [63:0] cap, input int n);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < n; i++) r[i] = (i < len) ? cap[i] : DIN[i-len];
        return r;
    endfunction

    function automatic string req_of(input logic [2:0] code);
        case (code)
            3'b000:  return "R7";
            3'b001:  return "R4";
            3'b010:  return "R8";
            3'b100:  return "R6";
            default: return "R5";
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge tck);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [63:0] dout;
        logic [2:0]  cap;
        repeat (3) step(1, 0);
        rst_n = 1'b1;
        // Reset state, R2 and R10
        check("R2 reset out_disable", {63'd0, out_disable}, 64'd0);
        check("R10 reset tdo/tdo_en", {62'd0, tdo_en, tdo}, 64'd0);
        step(0, 0);
        shift_dr(NSH, DIN, dout);
        check("R2 default is id", dout, expect_chain(32, {32'd0, ID_EXP}, NSH));

        // Table walk over all codes
        for (int e = 0; e < 8; e++) begin
            logic [2:0] code;
            logic [1:0] kind;
            int         len;
            logic [63:0] capv;
            code = VEC[e][5:3];
            kind = VEC[e][2:1];
            pin_vec = 16'hA5C3 ^ (16'h1111 * e[15:0]);
            load_ir(code, cap);
            check("R3 capture 001", {61'd0, cap}, 64'd1);
            check({req_of(code), " out_disable"}, {63'd0, out_disable}, {63'd0, VEC[e][0]});
            len  = (kind == 2'd0) ? 1 : (kind == 2'd1) ? 32 : BSR_LEN;
            capv = (kind == 2'd0) ? 64'd0 : (kind == 2'd1) ? {32'd0, ID_EXP} : {48'd0, pin_vec};
            shift_dr(NSH, DIN, dout);
            check({req_of(code), " chain"}, dout, expect_chain(len, capv, NSH));
        end

        // R1: five high tms from inside Shift-IR reaches reset and restores the default
        load_ir(3'b000, cap);
        check("R7 float active", {63'd0, out_disable}, 64'd1);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(0, 1);
        repeat (5) step(1, 0);
        check("R1 reset from shift-ir out_disable", {63'd0, out_disable}, 64'd0);
        check("R1 tdo_en off in reset", {63'd0, tdo_en}, 64'd0);
        step(0, 0);
        shift_dr(NSH, DIN, dout);
        check("R1 id after reset", dout, expect_chain(32, {32'd0, ID_EXP}, NSH));

        // R1: from inside Shift-DR under sample-hiZ
        load_ir(3'b010, cap);
        step(1, 0); step(0, 0); step(0, 0); step(0, 1);
        repeat (5) step(1, 0);
        check("R1 reset from shift-dr", {63'd0, out_disable}, 64'd0);
        step(0, 0);
        shift_dr(NSH, DIN, dout);
        check("R2 id after reset", dout, expect_chain(32, {32'd0, ID_EXP}, NSH));

        // R10: tdo changes on the falling edge only
        load_ir(3'b111, cap);
        step(1, 0); step(0, 0); step(0, 0);
        check("R10 bypass first bit", {63'd0, tdo}, 64'd0);
        tms = 1'b0;
        tdi = 1'b1;
        @(posedge tck);
        #1;
        check("R10 tdo held past rising edge", {63'd0, tdo}, 64'd0);
        @(negedge tck);
        #1;
        check("R10 tdo after falling edge", {63'd0, tdo}, 64'd1);
        step(1, 0); step(1, 0); step(0, 0);

        // R9: Update-DR under EXTEST keeps the float request
        load_ir(3'b000, cap);
        pin_vec = 16'h3C5A;
        shift_dr(NSH, DIN, dout);
        check("R9 float kept after update-dr", {63'd0, out_disable}, 64'd1);
        check("R7 snapshot", dout, expect_chain(BSR_LEN, {48'd0, 16'h3C5A}, NSH));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule